// File: doc/BRIEF.md
# Oversampled Serial Line Receiver with Start-Bit Qualification

This block turns a serial data line into bytes. It supports two timing schemes. In the asynchronous scheme, an external baud generator supplies a tick at sixteen times the bit rate. A falling edge on the line is treated as a start bit only if the line is still low half a bit later. After that, one sample is taken every sixteen ticks. In the clocked scheme, the line is sampled on each rising edge of an external serial clock. A low sample while idle is taken as a start bit at once.

Each frame carries eight data bits, least significant bit first. An even parity bit may follow, then one stop bit. Received bytes go into a 16-bit receive buffer. A parity-error flag and a framing-error flag are stored beside each byte. A one-cycle completion pulse is raised either after every frame or after every second frame. In two-frame mode, the first byte lands in the low half of the buffer and the second in the high half.

A frame whose stop bit is sampled low still completes normally. The receiver then refuses to look for a new start bit until it has seen the line high. A line stuck low therefore produces exactly one frame. Clearing the enable returns the receiver to idle and leaves the buffer untouched.

Top module: `serial_rx`

## Requirements
- R1: While `rx_en` is 0, the receiver stays idle and `rx_irq` stays 0. `rx_data`, `par_err` and `frm_err` keep their values. After reset, all outputs are 0.
- R2: With `sync_mode`=0, a falling edge on `rxd` is confirmed as a start bit when `rxd` is still low at the eighth `os_tick` after the edge.
- R3: With `sync_mode`=0, an edge whose eighth-tick sample is high is rejected. No frame is produced, and the receiver waits for the next falling edge, which is then received correctly.
- R4: After a confirmed start bit, each following bit is sampled every 16 ticks. The sampled bits are: 8 data bits LSB first, then a parity bit when `parity_en`=1, then the stop bit. The byte is stored in bits [7:0] of `rx_data` (one-frame mode).
- R5: With `sync_mode`=1, `rxd` is sampled on each rising edge of `ser_clk`. A low sample while idle starts a frame with no recheck, and each later rising edge samples one bit.
- R6: With `two_frame`=1, the first byte goes to `rx_data[7:0]` and `par_err[0]`/`frm_err[0]`. The second byte goes to `rx_data[15:8]` and `par_err[1]`/`frm_err[1]`. `rx_irq` pulses only after the second byte. With `two_frame`=0, every frame writes the low half and pulses `rx_irq`.
- R7: A frame whose stop bit is sampled low still completes and pulses `rx_irq`. No new frame starts until `rxd` has been seen high, in either mode.
- R8: The parity-error flag is 1 when `parity_en`=1 and the parity bit differs from the XOR of the 8 data bits (even parity). The framing-error flag is 1 when the stop bit is sampled low.
- R9: `rx_irq` is high for exactly one clock cycle per completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| sync_mode | input | 1 | 0: oversampled asynchronous, 1: serial-clock sampled |
| two_frame | input | 1 | 1: interrupt every second frame |
| parity_en | input | 1 | 1: frame carries an even parity bit |
| os_tick | input | 1 | Oversampling tick, 16 per bit, one cycle wide |
| ser_clk | input | 1 | External serial clock for the clocked mode |
| rxd | input | 1 | Serial data line, idle high |
| rx_data | output | 16 | Receive buffer, low byte then high byte |
| par_err | output | 2 | Parity-error flag per buffer half |
| frm_err | output | 2 | Framing-error flag per buffer half |
| rx_irq | output | 1 | One-cycle completion pulse |

## Verification
The hardest state to reach is the lock-out after a stop bit sampled low. It only shows when the line then stays low while sampling keeps running. This matters most in the clocked mode, where any low sample on an armed receiver would start a frame.

The stimulus sends a frame whose stop bit is low and holds the line low through dozens of further serial clock edges. It then counts that exactly one completion pulse occurred. The same approach exposes rejected start edges: a short low glitch is followed by a long quiet window before a good frame.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_HUNT = 2'd1,
    RX_BITS = 2'd2
  } rx_state_e;
endpackage

// File: rtl/serial_rx_sync.sv
// Multi-stage synchronizer with one extra delayed copy for edge detection.
module serial_rx_sync #(
  parameter int            W       = 2,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_LVL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] dprev
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_n;
  logic [W-1:0]             prev_q;

  always_comb begin
    chain_n[0] = din;
    for (int i = 1; i < STAGES; i++) chain_n[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_LVL}};
      prev_q  <= RST_LVL;
    end else begin
      chain_q <= chain_n;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign dout  = chain_q[STAGES-1];
  assign dprev = prev_q;
endmodule

// File: rtl/serial_rx_engine.sv
// Start-bit qualification and bit sampling for both timing schemes.
module serial_rx_engine
  import serial_rx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sync_mode,
  input  logic          parity_en,
  input  logic          tick,
  input  logic          line,
  input  logic          line_prev,
  input  logic          sclk_rise,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          perr,
  output logic          ferr
);
  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2;
  localparam int BW  = $clog2(DW + 2) + 1;

  rx_state_e     state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [BW-1:0] bidx_q, bidx_n;
  logic [DW-1:0] shreg_q, shreg_n;
  logic          par_q, par_n;
  logic          armed_q, armed_n;
  logic          done_q, done_n;
  logic [DW-1:0] data_q, data_n;
  logic          perr_q, perr_n;
  logic          ferr_q, ferr_n;
  logic          fall;
  logic          sample_now;

  assign fall = line_prev & ~line;

  always_comb begin
    state_n    = state_q;
    cnt_n      = cnt_q;
    bidx_n     = bidx_q;
    shreg_n    = shreg_q;
    par_n      = par_q;
    armed_n    = armed_q;
    done_n     = 1'b0;
    data_n     = data_q;
    perr_n     = perr_q;
    ferr_n     = ferr_q;
    sample_now = 1'b0;

    if (!en) begin
      state_n = RX_IDLE;
      cnt_n   = '0;
      bidx_n  = '0;
      armed_n = 1'b0;
    end else begin
      if (line) armed_n = 1'b1;
      unique case (state_q)
        RX_IDLE: begin
          cnt_n  = '0;
          bidx_n = '0;
          if (armed_q) begin
            if (sync_mode) begin
              if (sclk_rise && !line) state_n = RX_BITS;
            end else if (fall) begin
              state_n = RX_HUNT;
            end
          end
        end
        RX_HUNT: begin
          if (sync_mode) begin
            state_n = RX_IDLE;
            cnt_n   = '0;
          end else if (tick) begin
            if (cnt_q == CW'(MID - 1)) begin
              cnt_n   = '0;
              state_n = line ? RX_IDLE : RX_BITS;
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        RX_BITS: begin
          if (sync_mode) begin
            sample_now = sclk_rise;
          end else if (tick) begin
            sample_now = (cnt_q == CW'(OVS - 1));
            cnt_n      = sample_now ? '0 : cnt_q + 1'b1;
          end
          if (sample_now) begin
            bidx_n = bidx_q + 1'b1;
            if (bidx_q < BW'(DW)) begin
              shreg_n = {line, shreg_q[DW-1:1]};
            end else if (parity_en && (bidx_q == BW'(DW))) begin
              par_n = line;
            end else begin
              done_n  = 1'b1;
              data_n  = shreg_q;
              perr_n  = parity_en & (par_q ^ (^shreg_q));
              ferr_n  = ~line;
              if (!line) armed_n = 1'b0;
              state_n = RX_IDLE;
              bidx_n  = '0;
              cnt_n   = '0;
            end
          end
        end
        default: state_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      data_q  <= '0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      bidx_q  <= bidx_n;
      shreg_q <= shreg_n;
      par_q   <= par_n;
      armed_q <= armed_n;
      done_q  <= done_n;
      data_q  <= data_n;
      perr_q  <= perr_n;
      ferr_q  <= ferr_n;
    end
  end

  assign done = done_q;
  assign data = data_q;
  assign perr = perr_q;
  assign ferr = ferr_q;

  // R1: a cleared enable forces the idle state on the next cycle
  p_idle_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> state_q == RX_IDLE);
  // R2: the start qualification window never exceeds half a bit
  p_hunt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == RX_HUNT |-> cnt_q < CW'(MID));
  // R4: bit index never runs past data, parity and stop
  p_bits_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bidx_q <= BW'(DW + 1));
  // R5: in the clocked scheme a low sample on an armed receiver starts a frame
  p_sync_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sync_mode && state_q == RX_IDLE && armed_q && sclk_rise && !line)
      |=> state_q == RX_BITS);
  // R7: a disarmed receiver cannot leave idle
  p_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_IDLE && !armed_q) |=> state_q == RX_IDLE);
  // R7: a frame that ends on a low stop bit leaves the receiver disarmed
  p_ferr_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && ferr_q) |-> !armed_q);
endmodule

// File: rtl/serial_rx_buffer.sv
// Two-lane receive buffer with one- or two-frame completion gating.
module serial_rx_buffer #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            two_frame,
  input  logic            wr,
  input  logic [DW-1:0]   din,
  input  logic            pin,
  input  logic            fin,
  output logic [2*DW-1:0] buf_o,
  output logic [1:0]      perr_o,
  output logic [1:0]      ferr_o,
  output logic            irq
);
  localparam int NLANE = 2;

  logic slot_q, slot_n;
  logic irq_q, irq_n;
  logic wr_ok;

  assign wr_ok = wr & en;

  always_comb begin
    slot_n = slot_q;
    irq_n  = 1'b0;
    if (!en) begin
      slot_n = 1'b0;
    end else if (wr) begin
      if (!two_frame) begin
        irq_n  = 1'b1;
        slot_n = 1'b0;
      end else if (!slot_q) begin
        slot_n = 1'b1;
      end else begin
        slot_n = 1'b0;
        irq_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      slot_q <= slot_n;
      irq_q  <= irq_n;
    end
  end

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    logic [DW-1:0] lane_q;
    logic          lp_q;
    logic          lf_q;
    logic          we;

    assign we = wr_ok & (two_frame ? (slot_q == 1'(k)) : (k == 0));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '0;
        lp_q   <= 1'b0;
        lf_q   <= 1'b0;
      end else if (we) begin
        lane_q <= din;
        lp_q   <= pin;
        lf_q   <= fin;
      end
    end

    assign buf_o[k*DW +: DW] = lane_q;
    assign perr_o[k]         = lp_q;
    assign ferr_o[k]         = lf_q;
  end

  assign irq = irq_q;

  // R9: completion is a single-cycle pulse
  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R1: while disabled no pulse follows and the buffer holds
  p_quiet_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!irq_q && $stable(buf_o) && $stable(perr_o) && $stable(ferr_o)));
  // R6: the first frame of a pair raises no pulse
  p_first_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr && two_frame && !slot_q) |=> !irq_q);
endmodule

// File: rtl/serial_rx.sv
module serial_rx #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_en,
  input  logic                sync_mode,
  input  logic                two_frame,
  input  logic                parity_en,
  input  logic                os_tick,
  input  logic                ser_clk,
  input  logic                rxd,
  output logic [2*DATA_W-1:0] rx_data,
  output logic [1:0]          par_err,
  output logic [1:0]          frm_err,
  output logic                rx_irq
);
  logic [1:0]        sy_cur;
  logic [1:0]        sy_prev;
  logic              fr_done;
  logic [DATA_W-1:0] fr_data;
  logic              fr_perr;
  logic              fr_ferr;
  logic              sclk_rise;

  // bit 0: data line (idles high), bit 1: serial clock
  serial_rx_sync #(
    .W      (2),
    .STAGES (SYNC_STAGES),
    .RST_LVL(2'b01)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({ser_clk, rxd}),
    .dout (sy_cur),
    .dprev(sy_prev)
  );

  assign sclk_rise = sy_cur[1] & ~sy_prev[1];

  serial_rx_engine #(
    .DW (DATA_W),
    .OVS(OVS)
  ) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (rx_en),
    .sync_mode(sync_mode),
    .parity_en(parity_en),
    .tick     (os_tick),
    .line     (sy_cur[0]),
    .line_prev(sy_prev[0]),
    .sclk_rise(sclk_rise),
    .done     (fr_done),
    .data     (fr_data),
    .perr     (fr_perr),
    .ferr     (fr_ferr)
  );

  serial_rx_buffer #(
    .DW(DATA_W)
  ) u_buffer (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (rx_en),
    .two_frame(two_frame),
    .wr       (fr_done),
    .din      (fr_data),
    .pin      (fr_perr),
    .fin      (fr_ferr),
    .buf_o    (rx_data),
    .perr_o   (par_err),
    .ferr_o   (frm_err),
    .irq      (rx_irq)
  );
endmodule

// File: tb/serial_rx_test.sv
`timescale 1ns/1ps
module serial_rx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic        sync_mode = 1'b0;
  logic        two_frame = 1'b0;
  logic        parity_en = 1'b0;
  logic        os_tick = 1'b0;
  logic        ser_clk = 1'b0;
  logic        rxd = 1'b1;
  logic [15:0] rx_data;
  logic [1:0]  par_err;
  logic [1:0]  frm_err;
  logic        rx_irq;

  int n_chk = 0;
  int n_bad = 0;
  int irq_cnt = 0;
  int dbl = 0;
  logic        irq_prev = 1'b0;
  logic [15:0] cap_d = '0;
  logic [1:0]  cap_p = '0;
  logic [1:0]  cap_f = '0;
  bit          done_flag = 1'b0;

  always #2.5 clk = ~clk;

  serial_rx uut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sync_mode(sync_mode),
    .two_frame(two_frame), .parity_en(parity_en), .os_tick(os_tick),
    .ser_clk(ser_clk), .rxd(rxd), .rx_data(rx_data), .par_err(par_err),
    .frm_err(frm_err), .rx_irq(rx_irq)
  );

  initial forever begin
    @(negedge clk);
    os_tick = ~os_tick;
  end

  initial forever begin
    @(negedge clk);
    if (rx_irq) begin
      irq_cnt++;
      cap_d = rx_data;
      cap_p = par_err;
      cap_f = frm_err;
    end
    if (rx_irq && irq_prev) dbl++;
    irq_prev = rx_irq;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic abit(logic v);
    rxd = v;
    idle(32);
  endtask

  task automatic send_async(logic [7:0] b, logic pen, logic badp, logic stopv);
    abit(1'b0);
    for (int i = 0; i < 8; i++) abit(b[i]);
    if (pen) abit((^b) ^ badp);
    abit(stopv);
  endtask

  task automatic sbit(logic v);
    ser_clk = 1'b0;
    rxd = v;
    idle(4);
    ser_clk = 1'b1;
    idle(4);
  endtask

  task automatic send_sync(logic [7:0] b, logic pen, logic badp, logic stopv);
    sbit(1'b0);
    for (int i = 0; i < 8; i++) sbit(b[i]);
    if (pen) sbit((^b) ^ badp);
    sbit(stopv);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    int base;
    logic [7:0] b1;
    logic [7:0] b2;
    idle(5);
    rst_n = 1'b1;
    idle(3);
    chk("R1 reset irq", 32'(rx_irq), 0);
    chk("R1 reset data", 32'(rx_data), 0);
    chk("R1 reset flags", 32'({par_err, frm_err}), 0);

    rx_en = 1'b1;
    idle(20);

    // R2/R4: asynchronous frames without parity
    for (int i = 0; i < 48; i++) begin
      b1 = 8'(i * 53 + 7);
      base = irq_cnt;
      send_async(b1, 1'b0, 1'b0, 1'b1);
      idle(40);
      chk("R2 one completion", 32'(irq_cnt - base), 1);
      chk("R4 async byte", 32'(cap_d[7:0]), 32'(b1));
      chk("R8 clean flags", 32'({cap_p[0], cap_f[0]}), 0);
    end

    // R8: even parity, every other frame corrupted
    parity_en = 1'b1;
    for (int i = 0; i < 32; i++) begin
      b1 = 8'(i * 29 + 3);
      base = irq_cnt;
      send_async(b1, 1'b1, 1'(i % 2), 1'b1);
      idle(40);
      chk("R4 parity frame count", 32'(irq_cnt - base), 1);
      chk("R4 parity byte", 32'(cap_d[7:0]), 32'(b1));
      chk("R8 parity flag", 32'(cap_p[0]), 32'(i % 2));
    end
    parity_en = 1'b0;

    // R3: short low glitches are rejected
    base = irq_cnt;
    rxd = 1'b0; idle(8); rxd = 1'b1; idle(600);
    rxd = 1'b0; idle(12); rxd = 1'b1; idle(600);
    chk("R3 glitch no frame", 32'(irq_cnt - base), 0);
    send_async(8'hA5, 1'b0, 1'b0, 1'b1);
    idle(40);
    chk("R3 recovery count", 32'(irq_cnt - base), 1);
    chk("R3 recovery byte", 32'(cap_d[7:0]), 32'h A5);

    // R1: disable mid-frame
    base = irq_cnt;
    abit(1'b0);
    for (int i = 0; i < 4; i++) abit(1'(8'h3C >> i));
    rx_en = 1'b0;
    for (int i = 4; i < 8; i++) abit(1'(8'h3C >> i));
    abit(1'b1);
    idle(40);
    chk("R1 no irq when off", 32'(irq_cnt - base), 0);
    chk("R1 buffer held", 32'(rx_data[7:0]), 32'h A5);
    rx_en = 1'b1;
    idle(40);
    send_async(8'h5A, 1'b0, 1'b0, 1'b1);
    idle(40);
    chk("R1 after re-enable", 32'(rx_data[7:0]), 32'h 5A);

    // R6: two frames per completion
    two_frame = 1'b1;
    for (int j = 0; j < 4; j++) begin
      b1 = 8'(j * 17 + 1);
      b2 = ~b1;
      base = irq_cnt;
      send_async(b1, 1'b0, 1'b0, 1'b1);
      idle(40);
      chk("R6 first half silent", 32'(irq_cnt - base), 0);
      send_async(b2, 1'b0, 1'b0, 1'b1);
      idle(40);
      chk("R6 pair completion", 32'(irq_cnt - base), 1);
      chk("R6 pair data", 32'(cap_d), 32'({b2, b1}));
    end
    two_frame = 1'b0;

    // R7: asynchronous stuck-low stop bit
    base = irq_cnt;
    send_async(8'h81, 1'b0, 1'b0, 1'b0);
    idle(32 * 36);
    chk("R7 async single frame", 32'(irq_cnt - base), 1);
    chk("R8 framing flag", 32'(cap_f[0]), 1);
    chk("R7 async byte", 32'(cap_d[7:0]), 32'h 81);
    rxd = 1'b1;
    idle(40);
    send_async(8'h42, 1'b0, 1'b0, 1'b1);
    idle(40);
    chk("R7 async resume", 32'(cap_d[7:0]), 32'h 42);

    // R5: clocked scheme sweep
    sync_mode = 1'b1;
    repeat (3) sbit(1'b1);
    for (int i = 0; i < 256; i++) begin
      base = irq_cnt;
      parity_en = 1'(i >> 1);
      send_sync(8'(i), parity_en, 1'(i >> 2) & parity_en, 1'b1);
      sbit(1'b1);
      sbit(1'b1);
      chk("R5 sync count", 32'(irq_cnt - base), 1);
      chk("R5 sync byte", 32'(cap_d[7:0]), 32'(i));
      chk("R8 sync parity", 32'(cap_p[0]), 32'(((i >> 2) & (i >> 1)) & 1));
    end
    parity_en = 1'b0;

    // R7: clocked stuck-low line must not restart
    base = irq_cnt;
    send_sync(8'h99, 1'b0, 1'b0, 1'b0);
    repeat (40) sbit(1'b0);
    chk("R7 sync single frame", 32'(irq_cnt - base), 1);
    chk("R7 sync framing flag", 32'(cap_f[0]), 1);
    sbit(1'b1);
    sbit(1'b1);
    send_sync(8'h66, 1'b0, 1'b0, 1'b1);
    sbit(1'b1);
    sbit(1'b1);
    chk("R7 sync resume", 32'(cap_d[7:0]), 32'h 66);

    // R6: clocked pair with per-half flags
    two_frame = 1'b1;
    parity_en = 1'b1;
    base = irq_cnt;
    send_sync(8'h12, 1'b1, 1'b1, 1'b1);
    sbit(1'b1);
    sbit(1'b1);
    chk("R6 sync first silent", 32'(irq_cnt - base), 0);
    send_sync(8'h34, 1'b1, 1'b0, 1'b1);
    sbit(1'b1);
    sbit(1'b1);
    chk("R6 sync pair data", 32'(cap_d), 32'h 3412);
    chk("R6 sync pair perr", 32'(cap_p), 32'b01);
    chk("R6 sync pair ferr", 32'(cap_f), 0);

    chk("R9 single-cycle pulses", 32'(dbl), 0);
    report();
  end
endmodule